// File: doc/BRIEF.md
# LCD Segment Display Memory Scanner

This block holds the picture for a multiplexed segment LCD and scans it without any help from the processor. Forty-two segments are stored two to a byte, one per nibble, across a window of 21 byte addresses. A processor writes and reads these bytes through a simple byte port at any time. A sequencer steps through the common phases, one step per `scan_tick` pulse. For each phase the block presents one select/deselect bit per segment, taken from the stored nibble bit that belongs to that common line.

A configuration strobe sets the duty ratio to 1/2, 1/3 or 1/4. The duty ratio sets how many commons are scanned before the phase wraps. The same strobe can release three upper segment groups from display duty. The memory of a released group still works as plain storage, but its segment outputs are held at deselect.

The sequencer is a four-state machine with the states PH_COM0, PH_COM1, PH_COM2 and PH_COM3. Its transitions are:

- A configuration strobe sends any state to PH_COM0.
- With no tick, every state holds.
- On a tick, PH_COM0 goes to PH_COM1.
- On a tick, PH_COM1 goes to PH_COM0 in 1/2 duty and to PH_COM2 otherwise.
- On a tick, PH_COM2 goes to PH_COM0 in 1/3 duty (or 1/2 duty) and to PH_COM3 in 1/4 duty.
- On a tick, PH_COM3 goes to PH_COM0.

Top module: `lcd_seg_scanner`

## Requirements
- R1: A write with `cpu_we` high to any address from 0x64 to 0x78 stores `cpu_wdata` at the next clock edge. `cpu_rdata` shows the stored byte in the same cycle as the address, with no read latency.
- R2: A write to an address outside 0x64–0x78 changes no stored byte. Reading such an address returns 0x00.
- R3: The byte at address 0x64+k holds segment 2k in bits 3..0 and segment 2k+1 in bits 7..4. Within a nibble, bit c belongs to common line c, for c from 0 to 3.
- R4: `seg_on[s]` is 1 (select) when the stored bit of segment s for the current common is 1. It is 0 (deselect) when that bit is 0. Writes to the memory reach `seg_on` on the edge that stores them, with no CPU read involved.
- R5: Each `scan_tick` pulse advances the phase by one. The phase goes back to common 0 after common 1 in 1/2 duty, after common 2 in 1/3 duty, and after common 3 in 1/4 duty.
- R6: `com_active` is one-hot: bit c is 1 only while common c is being scanned. Commons outside the duty ratio are never marked active.
- R7: `cfg_release` bit 0 releases segments 20–27, bit 1 releases segments 28–35 and bit 2 releases segments 36–41. A released segment outputs 0 whatever is stored. The memory bytes of a released group still read and write normally.
- R8: After reset every stored byte is 0x00, the phase is common 0, the duty ratio is 1/4 and no group is released.
- R9: A `cfg_we` pulse loads the duty code from `cfg_duty` (1 = 1/2, 2 = 1/3, 3 = 1/4; 0 keeps the current duty), loads `cfg_release`, and returns the phase to common 0. This takes priority over a tick in the same cycle.
- R10: Without `scan_tick` or `cfg_we`, the phase holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Byte address of the processor access |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` (combinational) |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_duty | input | 2 | Duty code: 1 = 1/2, 2 = 1/3, 3 = 1/4, 0 = keep the current duty |
| cfg_release | input | 3 | Release bits for the segment groups 20–27, 28–35 and 36–41 |
| scan_tick | input | 1 | Single-cycle pulse that advances the common phase |
| com_active | output | 4 | One-hot marker of the common being scanned |
| seg_on | output | 42 | Select bit per segment for the current common |

## Verification
The bench sets single bits one at a time in every byte and bit position, then scans all phases. This catches a swapped nibble, a reversed common order or an off-by-one byte index, because such an error would light the wrong segment or light it in the wrong phase. It walks each duty ratio through more than one full cycle. This exposes a wrap one common too early or too late, which would mark an unused common active or skip a used one. It applies all eight release patterns and writes into released bytes. This shows both a group whose mask stops at the wrong boundary and a release that wrongly blocks storage. Writes just outside the window at 0x63 and 0x79 check that edge addresses neither alias into the memory nor read back nonzero.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

    localparam int N_COM = 4;
    localparam int PH_W  = 2;

    typedef enum logic [1:0] {
        DUTY_KEEP    = 2'd0,
        DUTY_HALF    = 2'd1,
        DUTY_THIRD   = 2'd2,
        DUTY_QUARTER = 2'd3
    } duty_e;

    typedef enum logic [PH_W-1:0] {
        PH_COM0 = 2'd0,
        PH_COM1 = 2'd1,
        PH_COM2 = 2'd2,
        PH_COM3 = 2'd3
    } phase_e;

endpackage

// File: rtl/lcdscan_ctrl.sv
module lcdscan_ctrl
    import lcdscan_pkg::*;
#(
    parameter int N_GRP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_duty,
    input  logic [N_GRP-1:0] cfg_release,
    output duty_e            duty_q,
    output logic [N_GRP-1:0] release_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q    <= DUTY_QUARTER;
            release_q <= '0;
        end else if (cfg_we) begin
            if (duty_e'(cfg_duty) != DUTY_KEEP) begin
                duty_q <= duty_e'(cfg_duty);
            end
            release_q <= cfg_release;
        end
    end

endmodule

// File: rtl/lcdscan_seq.sv
module lcdscan_seq
    import lcdscan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic             cfg_we,
    input  duty_e            duty_q,
    output logic [PH_W-1:0]  phase_idx,
    output logic [N_COM-1:0] com_active
);

    phase_e state_q;
    phase_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_COM0;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d = PH_COM0;
        end else if (scan_tick) begin
            unique case (state_q)
                PH_COM0: state_d = PH_COM1;
                PH_COM1: state_d = (duty_q == DUTY_HALF) ? PH_COM0 : PH_COM2;
                PH_COM2: state_d = (duty_q == DUTY_QUARTER) ? PH_COM3 : PH_COM0;
                PH_COM3: state_d = PH_COM0;
                default: state_d = PH_COM0;
            endcase
        end
    end

    // outputs
    always_comb begin
        com_active = '0;
        phase_idx  = state_q;
        unique case (state_q)
            PH_COM0: com_active[0] = 1'b1;
            PH_COM1: com_active[1] = 1'b1;
            PH_COM2: com_active[2] = 1'b1;
            PH_COM3: com_active[3] = 1'b1;
            default: com_active    = '0;
        endcase
    end

endmodule

// File: rtl/lcdscan_mem.sv
module lcdscan_mem
    import lcdscan_pkg::*;
#(
    parameter int              N_SEG     = 42,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_we,
    input  logic [2*N_COM-1:0]       cpu_wdata,
    output logic [2*N_COM-1:0]       cpu_rdata,
    output logic [N_SEG*N_COM-1:0]   seg_bits
);

    localparam int DATA_W  = 2 * N_COM;
    localparam int N_BYTES = N_SEG / 2;

    logic [DATA_W-1:0]  mem_q [N_BYTES];
    logic [N_BYTES-1:0] hit;

    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        assign hit[k] = (cpu_addr == (BASE_ADDR + ADDR_W'(k)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[k] <= '0;
            end else if (cpu_we && hit[k]) begin
                mem_q[k] <= cpu_wdata;
            end
        end

        // low nibble: even segment, high nibble: odd segment
        assign seg_bits[k*DATA_W +: DATA_W] = mem_q[k];
    end

    always_comb begin
        cpu_rdata = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            if (hit[k]) begin
                cpu_rdata = mem_q[k];
            end
        end
    end

endmodule

// File: rtl/lcdscan_segmux.sv
module lcdscan_segmux
    import lcdscan_pkg::*;
#(
    parameter int N_SEG   = 42,
    parameter int N_GRP   = 3,
    parameter int GRP0_LO = 20,
    parameter int GRP1_LO = 28,
    parameter int GRP2_LO = 36
) (
    input  logic [N_SEG*N_COM-1:0] seg_bits,
    input  logic [PH_W-1:0]        phase_idx,
    input  logic [N_GRP-1:0]       release_q,
    output logic [N_SEG-1:0]       seg_on
);

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        localparam int GRP = (s >= GRP2_LO) ? 2 :
                             (s >= GRP1_LO) ? 1 :
                             (s >= GRP0_LO) ? 0 : -1;
        logic [N_COM-1:0] nib;
        assign nib = seg_bits[s*N_COM +: N_COM];

        if (GRP < 0) begin : g_fixed
            assign seg_on[s] = nib[phase_idx];
        end else begin : g_shared
            assign seg_on[s] = nib[phase_idx] & ~release_q[GRP];
        end
    end

endmodule

// File: rtl/lcd_seg_scanner.sv
module lcd_seg_scanner
    import lcdscan_pkg::*;
#(
    parameter int                N_SEG     = 42,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h64,
    parameter int                GRP0_LO   = 20,
    parameter int                GRP1_LO   = 28,
    parameter int                GRP2_LO   = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_duty,
    input  logic [2:0]        cfg_release,
    input  logic              scan_tick,
    output logic [3:0]        com_active,
    output logic [N_SEG-1:0]  seg_on
);

    localparam int N_GRP = 3;

    duty_e                 duty_q;
    logic [N_GRP-1:0]      release_q;
    logic [PH_W-1:0]       phase_idx;
    logic [N_SEG*N_COM-1:0] seg_bits;

    lcdscan_ctrl #(.N_GRP(N_GRP)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_duty    (cfg_duty),
        .cfg_release (cfg_release),
        .duty_q      (duty_q),
        .release_q   (release_q)
    );

    lcdscan_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_tick  (scan_tick),
        .cfg_we     (cfg_we),
        .duty_q     (duty_q),
        .phase_idx  (phase_idx),
        .com_active (com_active)
    );

    lcdscan_mem #(
        .N_SEG     (N_SEG),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .seg_bits  (seg_bits)
    );

    lcdscan_segmux #(
        .N_SEG   (N_SEG),
        .N_GRP   (N_GRP),
        .GRP0_LO (GRP0_LO),
        .GRP1_LO (GRP1_LO),
        .GRP2_LO (GRP2_LO)
    ) u_mux (
        .seg_bits  (seg_bits),
        .phase_idx (phase_idx),
        .release_q (release_q),
        .seg_on    (seg_on)
    );

endmodule

// File: rtl/lcdscan_chk.sv
module lcdscan_chk #(
    parameter int                N_SEG     = 42,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h64,
    parameter int                GRP0_LO   = 20,
    parameter int                GRP1_LO   = 28,
    parameter int                GRP2_LO   = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [7:0]        cpu_rdata,
    input logic              cfg_we,
    input logic              scan_tick,
    input logic [1:0]        duty_q,
    input logic [2:0]        release_q,
    input logic [3:0]        com_active,
    input logic [N_SEG-1:0]  seg_on
);

    localparam int N_BYTES = N_SEG / 2;

    logic             out_win;
    logic [N_SEG-1:0] rel_mask;

    assign out_win = (cpu_addr < BASE_ADDR) ||
                     (cpu_addr > BASE_ADDR + ADDR_W'(N_BYTES - 1));

    always_comb begin
        rel_mask = '0;
        for (int s = 0; s < N_SEG; s++) begin
            if (s >= GRP2_LO)      rel_mask[s] = release_q[2];
            else if (s >= GRP1_LO) rel_mask[s] = release_q[1];
            else if (s >= GRP0_LO) rel_mask[s] = release_q[0];
        end
    end

    // R6
    com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_active) == 1);

    // R5
    half_duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == 2'd1) |-> (com_active[3:2] == 2'b00));

    // R5
    third_duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == 2'd2) |-> !com_active[3]);

    // R5
    half_duty_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !cfg_we && duty_q == 2'd1 && com_active[1]) |=> com_active[0]);

    // R5
    first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !cfg_we && com_active[0]) |=> com_active[1]);

    // R9
    cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (com_active == 4'b0001));

    // R10
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_tick && !cfg_we) |=> $stable(com_active));

    // R2
    outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_win |-> (cpu_rdata == 8'h00));

    // R7
    released_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_on & rel_mask) == '0));

endmodule

bind lcd_seg_scanner lcdscan_chk #(
    .N_SEG     (N_SEG),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .GRP0_LO   (GRP0_LO),
    .GRP1_LO   (GRP1_LO),
    .GRP2_LO   (GRP2_LO)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_rdata  (cpu_rdata),
    .cfg_we     (cfg_we),
    .scan_tick  (scan_tick),
    .duty_q     (duty_q),
    .release_q  (release_q),
    .com_active (com_active),
    .seg_on     (seg_on)
);

// File: tb/lcd_seg_scanner_tb.sv
module lcd_seg_scanner_tb;

    localparam int N_SEG   = 42;
    localparam int N_BYTES = 21;
    localparam logic [7:0] BASE = 8'h64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_addr = 8'h00;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_duty = 2'd0;
    logic [2:0]  cfg_release = 3'd0;
    logic        scan_tick = 1'b0;
    logic [3:0]  com_active;
    logic [N_SEG-1:0] seg_on;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] ref_mem [N_BYTES];
    int         ref_ncom;
    int         ref_phase;
    logic [2:0] ref_rel;

    always #2.5 clk = ~clk;

    lcd_seg_scanner u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_we      (cpu_we),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .cfg_we      (cfg_we),
        .cfg_duty    (cfg_duty),
        .cfg_release (cfg_release),
        .scan_tick   (scan_tick),
        .com_active  (com_active),
        .seg_on      (seg_on)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N_SEG-1:0] exp_seg();
        logic [N_SEG-1:0] v = '0;
        for (int s = 0; s < N_SEG; s++) begin
            logic [7:0] b = ref_mem[s/2];
            logic [3:0] nib = (s % 2 == 1) ? b[7:4] : b[3:0];
            logic rel = (s >= 36) ? ref_rel[2] : (s >= 28) ? ref_rel[1] :
                        (s >= 20) ? ref_rel[0] : 1'b0;
            v[s] = nib[ref_phase] & ~rel;
        end
        return v;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        if (a >= BASE && a < BASE + 8'(N_BYTES)) ref_mem[a - BASE] = d;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        logic [7:0] e;
        cpu_addr = a;
        #1;
        e = (a >= BASE && a < BASE + 8'(N_BYTES)) ? ref_mem[a - BASE] : 8'h00;
        chk(req, 64'(cpu_rdata), 64'(e));
    endtask

    task automatic tick();
        @(negedge clk);
        scan_tick = 1'b1;
        @(negedge clk);
        scan_tick = 1'b0;
        ref_phase = (ref_phase + 1) % ref_ncom;
    endtask

    task automatic cfg(input logic [1:0] duty, input logic [2:0] rel);
        @(negedge clk);
        cfg_we = 1'b1; cfg_duty = duty; cfg_release = rel;
        @(negedge clk);
        cfg_we = 1'b0;
        if (duty != 2'd0) ref_ncom = int'(duty) + 1;
        ref_rel = rel;
        ref_phase = 0;
    endtask

    task automatic chk_out(input string req);
        chk({req, " com"}, 64'(com_active), 64'(4'b0001 << ref_phase));
        chk({req, " seg"}, 64'(seg_on), 64'(exp_seg()));
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < N_BYTES; k++) ref_mem[k] = 8'h00;
        ref_ncom = 4; ref_phase = 0; ref_rel = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk_out("R8");
        for (int k = 0; k < N_BYTES; k++) rd_chk("R8", BASE + 8'(k));

        // R1 fill and read back
        for (int k = 0; k < N_BYTES; k++) wr(BASE + 8'(k), 8'((k * 37 + 11) & 255));
        for (int k = 0; k < N_BYTES; k++) rd_chk("R1", BASE + 8'(k));
        chk_out("R4");

        // R2 writes outside the window
        wr(8'h63, 8'hFF); wr(8'h79, 8'hFF); wr(8'h00, 8'hA5); wr(8'hFF, 8'h5A);
        rd_chk("R2", 8'h63); rd_chk("R2", 8'h79); rd_chk("R2", 8'h00); rd_chk("R2", 8'hFF);
        for (int k = 0; k < N_BYTES; k++) rd_chk("R2", BASE + 8'(k));

        // R5 R6 R4 scanning in each duty
        for (int d = 3; d >= 1; d--) begin
            cfg(2'(d), 3'b000);
            chk_out("R9");
            for (int t = 0; t < 9; t++) begin
                tick();
                chk_out("R5");
            end
        end

        // R10 hold without tick
        cfg(2'd3, 3'b000);
        tick(); tick();
        repeat (5) begin
            @(negedge clk);
            chk_out("R10");
        end

        // R9 duty code 0 keeps duty, phase returns to common 0
        cfg(2'd0, 3'b000);
        chk_out("R9");
        for (int t = 0; t < 5; t++) begin
            tick();
            chk_out("R9");
        end

        // R9 cfg has priority over tick
        tick();
        @(negedge clk);
        cfg_we = 1'b1; cfg_duty = 2'd3; cfg_release = 3'b000; scan_tick = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; scan_tick = 1'b0; ref_phase = 0;
        chk_out("R9");

        // R7 all release patterns, storage still usable
        for (int r = 0; r < 8; r++) begin
            cfg(2'd3, 3'(r));
            for (int k = 10; k < N_BYTES; k++) wr(BASE + 8'(k), 8'((k * 53 + r * 29) & 255));
            for (int k = 10; k < N_BYTES; k++) rd_chk("R7", BASE + 8'(k));
            for (int t = 0; t < 4; t++) begin
                chk_out("R7");
                tick();
            end
        end

        // R3 single-bit sweep over every byte and bit
        cfg(2'd3, 3'b000);
        for (int k = 0; k < N_BYTES; k++) wr(BASE + 8'(k), 8'h00);
        for (int k = 0; k < N_BYTES; k++) begin
            for (int b = 0; b < 8; b++) begin
                wr(BASE + 8'(k), 8'(1 << b));
                for (int t = 0; t < 4; t++) begin
                    chk_out("R3");
                    tick();
                end
            end
            wr(BASE + 8'(k), 8'h00);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule